// File: doc/BRIEF.md
# Shared-Clock Channel Select Front End

This block is the digital control front end of a multi-input sampling converter whose serial interface and converter share one common clock, here called the shared clock (`sclk`). A fast core clock (`clk`) oversamples `sclk`, the active-low select `cs_n` and the serial data `sdi`. All three pass through one synchronizer of equal depth, so they stay aligned with each other. A change of select is recognized only after two rising edges and then one falling edge of `sclk`. The two clocks used for recognition carry no address. The next eight clocks are the valid I/O clocks. They shift in the channel address MSB first.

On the falling edge of the fourth valid clock the block opens the sampling window. On the falling edge of the eighth valid clock it latches the address and emits a one-cycle hold strobe. On that same edge it closes the sampling window and starts a conversion of fixed length. A host can hold `sclk` high through the eighth valid cycle, and the sampling window stays open until the host lowers the clock. This lets the host choose the exact moment of conversion. If `sclk` keeps running while select is still low after the eighth valid clock, the address would be corrupted, so the block raises an error flag.

The block has no streaming data path, and so it has no valid/ready handshake. The latched channel address is a plain level output with no back-pressure. It holds its value until the next hold strobe.

Top module: `shclk_chsel_fe`

## Requirements
- R1: A synchronous active-high reset clears `chan_addr`, `sampling`, `hold_pulse`, `busy` and `addr_err`, and treats select as high.
- R2: After `cs_n` falls, the first two `sclk` clocks shift no address bit. The address is taken from the next eight rising edges, MSB first, and appears on `chan_addr` at the eighth valid falling edge.
- R3: `sampling` rises on the falling edge of the fourth valid clock (the sixth clock after `cs_n` falls) and is low before that edge.
- R4: On the falling edge of the eighth valid clock, `hold_pulse` is high for exactly one core cycle. On the same edge `sampling` goes low and `chan_addr` updates. `chan_addr` changes at no other time.
- R5: While `sclk` is held high in the eighth valid cycle, `sampling` stays high, and `hold_pulse` and `busy` stay low until `sclk` falls.
- R6: `busy` rises with the hold strobe. It stays high for 35 further `sclk` falling edges and clears on the 36th falling edge counted from the hold edge exclusive.
- R7: A `cs_n` fall while `busy` is high is ignored. No new frame starts until `cs_n` has been seen high after the conversion.
- R8: An `sclk` rising edge after the eighth valid clock while `cs_n` has stayed low sets `addr_err` and leaves `chan_addr` unchanged. `addr_err` clears when the next select is recognized.
- R9: Raising `cs_n` before the eighth valid falling edge aborts the frame. `sampling` drops, and no hold strobe or address update follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Shared serial and conversion clock |
| cs_n | input | 1 | Active-low select |
| sdi | input | 1 | Serial channel address in, MSB first |
| chan_addr | output | ADDR_W | Latched channel address |
| sampling | output | 1 | Sampling window open |
| hold_pulse | output | 1 | One-cycle hold and conversion-start strobe |
| busy | output | 1 | Conversion in progress |
| addr_err | output | 1 | Extra clocks seen while select stayed low |

## Verification
The closing of the sampling window and the hold strobe (with the address latch and the rise of busy) fall in the same core cycle on the eighth valid falling edge. The bench provokes this in every frame. It also provokes it in a directed test that keeps `sclk` high through the eighth valid cycle, and then checks that sampling is still open and no strobe has appeared before the late falling edge. After that edge it checks that exactly one strobe was counted, that sampling is closed, that busy is set and that the new address is present. Assertions in the checker require that each strobe coincides with sampling dropping from high, that busy rises only with a strobe, and that the address moves only with a strobe.

// File: rtl/shclk_chsel_pkg.sv
package shclk_chsel_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RECOG = 2'd1,
    ST_SHIFT = 2'd2,
    ST_CONV  = 2'd3
  } fe_state_t;

  // bit positions inside the synchronized input bundle
  localparam int unsigned IN_SDI  = 0;
  localparam int unsigned IN_SCLK = 1;
  localparam int unsigned IN_CSN  = 2;
  localparam int unsigned IN_W    = 3;

endpackage

// File: rtl/shclk_chsel_sync.sv
module shclk_chsel_sync #(
  parameter int unsigned W       = 3,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [STAGES-1:0][W-1:0] stg;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) stg <= RST_VAL;
        else     stg <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) stg <= {STAGES{RST_VAL}};
        else     stg <= {stg[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/shclk_chsel_edge.sv
module shclk_chsel_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise,
  output logic fall
);

  logic prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= lvl;
  end

  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;

endmodule

// File: rtl/shclk_chsel_count.sv
module shclk_chsel_count #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/shclk_chsel_shift.sv
module shclk_chsel_shift #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else if (en)    q <= {q[W-2:0], din};
  end

endmodule

// File: rtl/shclk_chsel_fe.sv
module shclk_chsel_fe
  import shclk_chsel_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned RECOG_RISES = 2,
  parameter int unsigned SAMPLE_AT   = 4,
  parameter int unsigned CONV_CLKS   = 36,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              sdi,
  output logic [ADDR_W-1:0] chan_addr,
  output logic              sampling,
  output logic              hold_pulse,
  output logic              busy,
  output logic              addr_err
);

  localparam int unsigned RC_W = $clog2(RECOG_RISES + 1);
  localparam int unsigned VC_W = $clog2(ADDR_W + 1);
  localparam int unsigned CC_W = $clog2(CONV_CLKS + 1);
  localparam logic [RC_W-1:0] RC_FULL = RC_W'(RECOG_RISES);
  localparam logic [VC_W-1:0] VC_SAMP = VC_W'(SAMPLE_AT - 1);
  localparam logic [VC_W-1:0] VC_LAST = VC_W'(ADDR_W - 1);
  localparam logic [CC_W-1:0] CC_LAST = CC_W'(CONV_CLKS - 1);
  localparam logic [IN_W-1:0] IN_RST  = IN_W'(1) << IN_CSN;

  // aligned synchronization of all three inputs
  logic [IN_W-1:0] raw_in, syn_in;
  assign raw_in[IN_SDI]  = sdi;
  assign raw_in[IN_SCLK] = sclk;
  assign raw_in[IN_CSN]  = cs_n;

  shclk_chsel_sync #(
    .W(IN_W), .STAGES(SYNC_STAGES), .RST_VAL(IN_RST)
  ) u_sync (
    .clk(clk), .rst(rst), .din(raw_in), .dout(syn_in)
  );

  logic s_rise, s_fall;
  shclk_chsel_edge u_edge (
    .clk(clk), .rst(rst), .lvl(syn_in[IN_SCLK]), .rise(s_rise), .fall(s_fall)
  );

  logic cs_lo, d_in;
  assign cs_lo = ~syn_in[IN_CSN];
  assign d_in  = syn_in[IN_SDI];

  fe_state_t state;
  logic      armed;
  logic      cs_raised;

  // recognition rise counter
  logic [RC_W-1:0] rcnt;
  logic rc_clr, rc_inc;
  assign rc_clr = (state != ST_RECOG);
  assign rc_inc = (state == ST_RECOG) && s_rise && (rcnt != RC_FULL);

  shclk_chsel_count #(.W(RC_W)) u_rcnt (
    .clk(clk), .rst(rst), .clr(rc_clr), .inc(rc_inc), .cnt(rcnt)
  );

  // valid falling-edge counter
  logic [VC_W-1:0] vcnt;
  logic vc_clr, vc_inc;
  assign vc_clr = (state != ST_SHIFT);
  assign vc_inc = (state == ST_SHIFT) && cs_lo && s_fall;

  shclk_chsel_count #(.W(VC_W)) u_vcnt (
    .clk(clk), .rst(rst), .clr(vc_clr), .inc(vc_inc), .cnt(vcnt)
  );

  // conversion falling-edge counter
  logic [CC_W-1:0] ccnt;
  logic cc_clr, cc_inc;
  assign cc_clr = (state != ST_CONV);
  assign cc_inc = (state == ST_CONV) && s_fall;

  shclk_chsel_count #(.W(CC_W)) u_ccnt (
    .clk(clk), .rst(rst), .clr(cc_clr), .inc(cc_inc), .cnt(ccnt)
  );

  // address shifter, valid rising edges only
  logic [ADDR_W-1:0] sh_q;
  logic sh_clr, sh_en;
  assign sh_clr = (state != ST_SHIFT);
  assign sh_en  = (state == ST_SHIFT) && cs_lo && s_rise;

  shclk_chsel_shift #(.W(ADDR_W)) u_shift (
    .clk(clk), .rst(rst), .clr(sh_clr), .en(sh_en), .din(d_in), .q(sh_q)
  );

  // control sequence
  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      armed      <= 1'b0;
      cs_raised  <= 1'b0;
      chan_addr  <= '0;
      sampling   <= 1'b0;
      hold_pulse <= 1'b0;
      busy       <= 1'b0;
      addr_err   <= 1'b0;
    end else begin
      hold_pulse <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (!cs_lo) begin
            armed <= 1'b1;
          end else if (armed) begin
            state <= ST_RECOG;
          end
        end
        ST_RECOG: begin
          if (!cs_lo) begin
            state <= ST_IDLE;
          end else if (s_fall && (rcnt == RC_FULL)) begin
            state    <= ST_SHIFT;
            addr_err <= 1'b0;
          end
        end
        ST_SHIFT: begin
          if (!cs_lo) begin
            state    <= ST_IDLE;
            sampling <= 1'b0;
          end else if (s_fall) begin
            if (vcnt == VC_SAMP) sampling <= 1'b1;
            if (vcnt == VC_LAST) begin
              sampling   <= 1'b0;
              hold_pulse <= 1'b1;
              busy       <= 1'b1;
              chan_addr  <= sh_q;
              cs_raised  <= 1'b0;
              state      <= ST_CONV;
            end
          end
        end
        ST_CONV: begin
          if (!cs_lo) cs_raised <= 1'b1;
          if (s_rise && cs_lo && !cs_raised) addr_err <= 1'b1;
          if (s_fall && (ccnt == CC_LAST)) begin
            busy  <= 1'b0;
            armed <= 1'b0;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/shclk_chsel_fe_chk.sv
module shclk_chsel_fe_chk #(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] chan_addr,
  input logic              sampling,
  input logic              hold_pulse,
  input logic              busy
);

  // R4: the strobe never lasts two cycles
  a_r4_hold_one_cycle: assert property (@(posedge clk) disable iff (rst)
    hold_pulse |=> !hold_pulse);

  // R4: the strobe coincides with sampling dropping from high
  a_r4_samp_drop: assert property (@(posedge clk) disable iff (rst)
    hold_pulse |-> (!sampling && $past(sampling)));

  // R4: the address moves only together with the strobe
  a_r4_addr_on_hold: assert property (@(posedge clk) disable iff (rst)
    !hold_pulse |-> $stable(chan_addr));

  // R6: busy starts only with a strobe
  a_r6_busy_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> hold_pulse);

  // R3: the sampling window never overlaps a conversion
  a_r3_no_samp_busy: assert property (@(posedge clk) disable iff (rst)
    sampling |-> !busy);

endmodule

bind shclk_chsel_fe shclk_chsel_fe_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .chan_addr(chan_addr), .sampling(sampling),
  .hold_pulse(hold_pulse), .busy(busy)
);

// File: tb/shclk_chsel_fe_tb_top.sv
module shclk_chsel_fe_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int CONV       = 36;
  localparam int NVEC       = 6;
  // entry: [9:2] address, [1] extra clock with select low, [0] expected error
  localparam logic [9:0] VECS [NVEC] = '{
    {8'hA5, 1'b0, 1'b0},
    {8'h00, 1'b0, 1'b0},
    {8'hFF, 1'b1, 1'b1},
    {8'h3C, 1'b0, 1'b0},
    {8'h81, 1'b1, 1'b1},
    {8'h5A, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst, sclk, cs_n, sdi;
  logic [7:0] chan_addr;
  logic sampling, hold_pulse, busy, addr_err;

  int checks = 0;
  int errors = 0;
  int hold_cnt = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shclk_chsel_fe dut_i (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .chan_addr(chan_addr), .sampling(sampling), .hold_pulse(hold_pulse),
    .busy(busy), .addr_err(addr_err)
  );

  always @(negedge clk) if (!rst && hold_pulse) hold_cnt++;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_half();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic pulse(input logic d);
    sdi = d;
    wait_half();
    sclk = 1'b1;
    wait_half();
    sclk = 1'b0;
    wait_half();
  endtask

  task automatic frame(input logic [7:0] a, input logic extra, input logic exp_err);
    int h0;
    int nconv;
    h0 = hold_cnt;
    cs_n = 1'b0;
    wait_half();
    pulse(1'b1);
    check("R3 no sampling in recognition clock 1", sampling, 0);
    pulse(1'b0);
    check("R3 no sampling in recognition clock 2", sampling, 0);
    for (int i = 0; i < 8; i++) begin
      pulse(a[7-i]);
      check("R3/R4 sampling window", sampling, (i + 3 >= 6 && i + 3 <= 9) ? 1 : 0);
    end
    check("R4 one hold strobe", hold_cnt - h0, 1);
    check("R2 latched address", chan_addr, a);
    check("R6 busy after hold", busy, 1);
    nconv = 0;
    if (extra) begin
      pulse(1'b0);
      nconv = 1;
    end
    cs_n = 1'b1;
    repeat (CONV - 1 - nconv) pulse(1'b0);
    check("R6 busy before last conversion clock", busy, 1);
    pulse(1'b0);
    check("R6 busy clear after conversion", busy, 0);
    check("R8 error flag", addr_err, exp_err);
    check("R8 address not corrupted", chan_addr, a);
  endtask

  initial begin
    rst = 1'b1; sclk = 1'b0; cs_n = 1'b1; sdi = 1'b0;
    repeat (5) @(negedge clk);
    check("R1 reset chan_addr", chan_addr, 0);
    check("R1 reset sampling", sampling, 0);
    check("R1 reset hold", hold_pulse, 0);
    check("R1 reset busy", busy, 0);
    check("R1 reset addr_err", addr_err, 0);
    rst = 1'b0;
    wait_half();

    // vector walk (R2 R3 R4 R6 R8)
    for (int v = 0; v < NVEC; v++) begin
      frame(VECS[v][9:2], VECS[v][1], VECS[v][0]);
      wait_half();
    end

    // R5: stretch the eighth valid high phase
    begin
      int h0;
      logic [7:0] a;
      a = 8'hC3;
      h0 = hold_cnt;
      cs_n = 1'b0;
      wait_half();
      pulse(1'b0); pulse(1'b0);
      for (int i = 0; i < 7; i++) pulse(a[7-i]);
      sdi = a[0];
      wait_half();
      sclk = 1'b1;
      repeat (5) wait_half();
      check("R5 sampling held open", sampling, 1);
      check("R5 no strobe while stretched", hold_cnt - h0, 0);
      check("R5 not busy while stretched", busy, 0);
      sclk = 1'b0;
      wait_half();
      check("R5 strobe after late fall", hold_cnt - h0, 1);
      check("R5 sampling closed", sampling, 0);
      check("R5 busy after late fall", busy, 1);
      check("R5 address", chan_addr, a);
      cs_n = 1'b1;
      repeat (CONV) pulse(1'b0);
      check("R6 busy clear after stretch frame", busy, 0);
    end

    // R7: select falls during busy and stays low
    begin
      int h0;
      frame(8'h96, 1'b0, 1'b0);
      cs_n = 1'b0;
      wait_half();
      cs_n = 1'b1;
      h0 = hold_cnt;
      // re-run a frame whose select falls mid-conversion
      cs_n = 1'b0;
      wait_half();
      pulse(1'b1); pulse(1'b0);
      for (int i = 0; i < 8; i++) pulse(1'b1);
      cs_n = 1'b1;
      repeat (5) pulse(1'b0);
      cs_n = 1'b0;
      repeat (CONV - 5) pulse(1'b0);
      check("R7 conversion ended", busy, 0);
      h0 = hold_cnt;
      for (int i = 0; i < 12; i++) pulse(1'b0);
      check("R7 no new strobe", hold_cnt - h0, 0);
      check("R7 address kept", chan_addr, 8'hFF);
      check("R7 no sampling", sampling, 0);
      check("R7 not busy", busy, 0);
      check("R7 no error from late select", addr_err, 0);
      cs_n = 1'b1;
      pulse(1'b0);
    end

    // R9: abort mid shift
    begin
      int h0;
      h0 = hold_cnt;
      cs_n = 1'b0;
      wait_half();
      pulse(1'b0); pulse(1'b0);
      for (int i = 0; i < 5; i++) pulse(1'b0);
      check("R9 sampling open before abort", sampling, 1);
      cs_n = 1'b1;
      pulse(1'b0); pulse(1'b0); pulse(1'b0);
      check("R9 sampling dropped", sampling, 0);
      check("R9 no strobe", hold_cnt - h0, 0);
      check("R9 address kept", chan_addr, 8'hFF);
      check("R9 not busy", busy, 0);
    end

    // R1: reset after activity
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset clears address", chan_addr, 0);
    check("R1 reset clears busy", busy, 0);
    rst = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule